// File: doc/BRIEF.md
# Serial CRC-3 Encoder and Checker

This block attaches and verifies three cyclic redundancy check bits on serial bit streams, using the generator polynomial x^3 + x + 1. The encoder takes information bits one per valid cycle, highest order first. It repeats each bit unchanged on its output one cycle later. After the final information bit it appends the three check bits. These check bits are the remainder of the information polynomial, shifted up by three places, divided by the generator. The resulting codeword is therefore divisible by the generator.

The checker is a separate serial channel. It pushes a received codeword through an identical divider. When the codeword ends, it raises an error flag if the final remainder is nonzero. The flag stays put until the next codeword begins. Both channels mark block boundaries with start and last qualifiers on valid cycles.

Top module: `crc_serial_codec`

## Requirements
- R1: The three check bits emitted by the encoder equal the remainder of x^3·i(x) modulo x^3+x+1 (divisor bits 1011), where i(x) has the first information bit as its highest-order term.
- R2: Every accepted information bit (enc_in_valid high) appears unchanged on enc_out_bit, with enc_out_valid high, exactly one cycle after it was presented.
- R3: The check bits follow the last information bit on the three immediately following output cycles, highest-order remainder bit first, with enc_out_valid high on each.
- R4: During the three cycles after an accepted last bit, all encoder inputs are ignored, so valid, start, last or data asserted then change neither the emitted check bits nor the next block.
- R5: A start marker on an accepted bit clears the remainder first, so each block's check bits depend only on that block's bits.
- R6: Information bits 1,1,0,0 produce the codeword 1,1,0,0,0,1,0.
- R7: One cycle after the last codeword bit, chk_err is high exactly when the codeword is not divisible by x^3+x+1.
- R8: chk_err holds its value until the cycle after the next accepted start bit, where it falls unless that bit is also the last one.
- R9: After synchronous reset, enc_out_valid and chk_err are low.
- R10: Cycles with enc_in_valid low inside a block do not alter the remainder and give enc_out_valid low one cycle later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enc_in_valid | input | 1 | Encoder input bit is present |
| enc_in_start | input | 1 | First information bit of a block |
| enc_in_last | input | 1 | Final information bit of a block |
| enc_in_bit | input | 1 | Information bit, highest order first |
| enc_out_valid | output | 1 | Codeword bit on enc_out_bit is present |
| enc_out_bit | output | 1 | Serial codeword bit |
| chk_in_valid | input | 1 | Checker input bit is present |
| chk_in_start | input | 1 | First codeword bit |
| chk_in_last | input | 1 | Final codeword bit |
| chk_in_bit | input | 1 | Received codeword bit |
| chk_err | output | 1 | Nonzero remainder in the last finished codeword |

## Verification
The bench builds the block with its default three-bit generator. Because the configuration is that small, it can sweep every information pattern of one to eight bits. The expected remainders come from integer long division. Every resulting codeword is fed back through the checker twice, once clean and once corrupted with a pattern-derived error mask. Junk inputs during the check-bit cycles and valid gaps inside blocks are mixed in across the sweep.

// File: rtl/crc_pkg.sv
package crc_pkg;
  parameter int unsigned CRC_W = 3;
  // low-order taps of x^3 + x + 1 (leading term implied)
  parameter logic [CRC_W-1:0] CRC_TAPS = 3'b011;
endpackage

// File: rtl/crc_divider.sv
module crc_divider #(
  parameter int unsigned W = crc_pkg::CRC_W,
  parameter logic [W-1:0] TAPS = crc_pkg::CRC_TAPS
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step,
  input  logic         first,
  input  logic         din,
  input  logic         shift,
  output logic [W-1:0] rem
);
  logic [W-1:0] base;
  logic         fb;
  logic [W-1:0] nxt;

  always_comb begin
    base = first ? '0 : rem;
    fb   = base[W-1] ^ din;
    nxt  = {base[W-2:0], 1'b0} ^ ({W{fb}} & TAPS);
  end

  always_ff @(posedge clk) begin
    if (rst)
      rem <= '0;
    else if (step)
      rem <= nxt;
    else if (shift)
      rem <= {rem[W-2:0], 1'b0};
  end

  // R5
  start_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (step && first && !din) |=> (rem == '0));
  // R3
  flush_fill_chk: assert property (@(posedge clk) disable iff (rst)
    (shift && !step) |=> (rem[0] == 1'b0));
endmodule

// File: rtl/crc_encoder.sv
module crc_encoder #(
  parameter int unsigned W = crc_pkg::CRC_W,
  parameter logic [W-1:0] TAPS = crc_pkg::CRC_TAPS
) (
  input  logic clk,
  input  logic rst,
  input  logic in_valid,
  input  logic in_start,
  input  logic in_last,
  input  logic in_bit,
  output logic out_valid,
  output logic out_bit
);
  localparam int unsigned CW = $clog2(W + 1);

  logic [CW-1:0] flush_cnt;
  logic [W-1:0]  rem;
  logic          flushing;
  logic          accept;

  assign flushing = (flush_cnt != '0);
  assign accept   = in_valid && !flushing;

  crc_divider #(.W(W), .TAPS(TAPS)) u_div (
    .clk(clk), .rst(rst), .step(accept), .first(in_start),
    .din(in_bit), .shift(flushing), .rem(rem)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_bit   <= 1'b0;
      flush_cnt <= '0;
    end else if (flushing) begin
      out_valid <= 1'b1;
      out_bit   <= rem[W-1];
      flush_cnt <= flush_cnt - 1'b1;
    end else if (in_valid) begin
      out_valid <= 1'b1;
      out_bit   <= in_bit;
      if (in_last) flush_cnt <= CW'(W);
    end else begin
      out_valid <= 1'b0;
    end
  end

  // R3
  flush_out_chk: assert property (@(posedge clk) disable iff (rst)
    flushing |=> out_valid);
  // R4
  flush_len_chk: assert property (@(posedge clk) disable iff (rst)
    (accept && in_last) |=> (flush_cnt == CW'(W)));
  // R10
  gap_chk: assert property (@(posedge clk) disable iff (rst)
    (!in_valid && !flushing) |=> !out_valid);
endmodule

// File: rtl/crc_checker.sv
module crc_checker #(
  parameter int unsigned W = crc_pkg::CRC_W,
  parameter logic [W-1:0] TAPS = crc_pkg::CRC_TAPS
) (
  input  logic clk,
  input  logic rst,
  input  logic in_valid,
  input  logic in_start,
  input  logic in_last,
  input  logic in_bit,
  output logic err
);
  logic [W-1:0] rem;
  logic [W-1:0] base;
  logic         fb;
  logic [W-1:0] final_rem;

  crc_divider #(.W(W), .TAPS(TAPS)) u_div (
    .clk(clk), .rst(rst), .step(in_valid), .first(in_start),
    .din(in_bit), .shift(1'b0), .rem(rem)
  );

  // remainder including the bit presented this cycle
  always_comb begin
    base      = in_start ? '0 : rem;
    fb        = base[W-1] ^ in_bit;
    final_rem = {base[W-2:0], 1'b0} ^ ({W{fb}} & TAPS);
  end

  always_ff @(posedge clk) begin
    if (rst)
      err <= 1'b0;
    else if (in_valid && in_last)
      err <= (final_rem != '0);
    else if (in_valid && in_start)
      err <= 1'b0;
  end

  // R8
  start_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_start && !in_last) |=> !err);
  // R8
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(in_valid && (in_start || in_last)) |=> $stable(err));
endmodule

// File: rtl/crc_serial_codec.sv
module crc_serial_codec #(
  parameter int unsigned W = crc_pkg::CRC_W,
  parameter logic [W-1:0] TAPS = crc_pkg::CRC_TAPS
) (
  input  logic clk,
  input  logic rst,
  input  logic enc_in_valid,
  input  logic enc_in_start,
  input  logic enc_in_last,
  input  logic enc_in_bit,
  output logic enc_out_valid,
  output logic enc_out_bit,
  input  logic chk_in_valid,
  input  logic chk_in_start,
  input  logic chk_in_last,
  input  logic chk_in_bit,
  output logic chk_err
);
  crc_encoder #(.W(W), .TAPS(TAPS)) u_enc (
    .clk(clk), .rst(rst), .in_valid(enc_in_valid), .in_start(enc_in_start),
    .in_last(enc_in_last), .in_bit(enc_in_bit),
    .out_valid(enc_out_valid), .out_bit(enc_out_bit)
  );

  crc_checker #(.W(W), .TAPS(TAPS)) u_chk (
    .clk(clk), .rst(rst), .in_valid(chk_in_valid), .in_start(chk_in_start),
    .in_last(chk_in_last), .in_bit(chk_in_bit), .err(chk_err)
  );

  // R9
  reset_quiet_chk: assert property (@(posedge clk)
    $past(rst) |-> (!enc_out_valid && !chk_err));
endmodule

// File: tb/test_crc_serial_codec.sv
module test_crc_serial_codec;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic enc_in_valid = 0, enc_in_start = 0, enc_in_last = 0, enc_in_bit = 0;
  logic chk_in_valid = 0, chk_in_start = 0, chk_in_last = 0, chk_in_bit = 0;
  logic enc_out_valid, enc_out_bit, chk_err;
  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  crc_serial_codec i_crc_serial_codec (
    .clk(clk), .rst(rst),
    .enc_in_valid(enc_in_valid), .enc_in_start(enc_in_start),
    .enc_in_last(enc_in_last), .enc_in_bit(enc_in_bit),
    .enc_out_valid(enc_out_valid), .enc_out_bit(enc_out_bit),
    .chk_in_valid(chk_in_valid), .chk_in_start(chk_in_start),
    .chk_in_last(chk_in_last), .chk_in_bit(chk_in_bit),
    .chk_err(chk_err)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // remainder of val (nb bits) modulo 1011 by long division
  function automatic int poly_mod(input int val, input int nb);
    int v = val;
    for (int pos = nb - 1; pos >= 3; pos--)
      if (v[pos]) v = v ^ (11 << (pos - 3));
    return v & 7;
  endfunction

  task automatic encode(input int info, input int k, input bit junk, input bit gap,
                        output int word, output bit vld_ok);
    word = 0;
    vld_ok = 1;
    for (int j = k - 1; j >= 0; j--) begin
      enc_in_valid = 1; enc_in_bit = info[j];
      enc_in_start = (j == k - 1); enc_in_last = (j == 0);
      @(negedge clk);
      vld_ok &= enc_out_valid;
      word = (word << 1) | int'(enc_out_bit);
      if (gap && j == k - 1 && k > 1) begin
        enc_in_valid = 0; enc_in_bit = 1; enc_in_start = 1; enc_in_last = 1;
        @(negedge clk);
        // R10
        check(!enc_out_valid, "R10", enc_out_valid, 0);
      end
    end
    for (int f = 0; f < 3; f++) begin
      enc_in_valid = junk; enc_in_bit = junk; enc_in_start = junk; enc_in_last = junk;
      @(negedge clk);
      vld_ok &= enc_out_valid;
      word = (word << 1) | int'(enc_out_bit);
    end
    enc_in_valid = 0; enc_in_start = 0; enc_in_last = 0; enc_in_bit = 0;
    @(negedge clk);
  endtask

  task automatic check_word(input int word, input int n, input string req);
    bit exp_err;
    exp_err = (poly_mod(word, n) != 0);
    for (int j = n - 1; j >= 0; j--) begin
      chk_in_valid = 1; chk_in_bit = word[j];
      chk_in_start = (j == n - 1); chk_in_last = (j == 0);
      @(negedge clk);
      if (j == n - 2) begin
        // R8: cleared after a start that is not last
        check(chk_err == 1'b0, "R8", chk_err, 0);
      end
    end
    chk_in_valid = 0; chk_in_start = 0; chk_in_last = 0;
    check(chk_err == exp_err, req, chk_err, exp_err);
    @(negedge clk);
    @(negedge clk);
    // R8: held while idle
    check(chk_err == exp_err, "R8", chk_err, exp_err);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int word, exp_word, n, mask;
    bit vok;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R9
    check(!enc_out_valid && !chk_err, "R9", {enc_out_valid, chk_err}, 0);

    // R6: worked example 1100 -> 1100010
    encode(4'b1100, 4, 1'b0, 1'b0, word, vok);
    check(word == 7'b1100010, "R6", word, 7'b1100010);

    for (int k = 1; k <= 8; k++) begin
      for (int p = 0; p < (1 << k); p++) begin
        n = k + 3;
        exp_word = (p << 3) | poly_mod(p << 3, n);
        encode(p, k, p[0], p[1], word, vok);
        // R1 R2 R3 R4 R5: full codeword, contiguous output, junk ignored
        check(word == exp_word, "R1", word, exp_word);
        check(vok, "R3", vok, 1);
        // R7: clean codeword
        check_word(exp_word, n, "R7");
        mask = ((p * 37 + k * 11) ^ (1 << (p % n))) & ((1 << n) - 1);
        check_word(exp_word ^ mask, n, "R7");
      end
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule